// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block answers a three-wire serial bus made of a level-sensitive chip-enable, a serial clock and one bidirectional data line. It contains two banks of byte-wide registers, one for clock/calendar values and one for general RAM. Each transaction opens with a command byte. That byte picks a bank, a register address and the direction. A single data byte is then written into the register or read out of it.

All three bus inputs are resynchronized into the block's own system clock. The serial clock edges are detected from those synchronized samples. The data line leaves the block as a data value and a separate output-enable, and the pad tristate sits outside the block. The register banks come out of reset cleared to zero.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset, every register in both banks reads as 0x00 and the output-enable is low.
- R2: While chip-enable is low, the output-enable is low. Dropping chip-enable ends any transfer at once.
- R3: The first eight bits after chip-enable rises form the command byte, shifted in least significant bit first on rising serial-clock edges. Command bit 0 chooses the direction: 0 means write and 1 means read.
- R4: Command bits 5..1 give the register address, with bit 1 as the address LSB. Writes to different addresses do not disturb each other.
- R5: Command bit 6 picks the bank: 0 selects clock/calendar and 1 selects RAM. The same address in the two banks refers to two independent registers.
- R6: When command bit 7 is 0, a write transaction leaves every register unchanged.
- R7: In a write, eight data bits are captured LSB first on rising edges. The register is updated only once the eighth bit has been captured with chip-enable still high. A transaction cut short leaves the register unchanged.
- R8: In a read, the output-enable stays low until the first falling serial-clock edge after the eighth command bit. The data bits are launched on falling edges, LSB first, and hold steady between falling edges.
- R9: The output-enable never rises during a write transaction.
- R10: Every rising edge of chip-enable starts a new command byte, whatever happened in the transaction before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Bus chip-enable; high frames a transaction |
| sclk_i | input | 1 | Bus serial clock |
| sd_i | input | 1 | Data line as seen at the pad input |
| sd_o | output | 1 | Data value to drive onto the line |
| sd_oe | output | 1 | Output-enable for the data line pad |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, byte-wide data and a five-bit address. This configuration reaches the lowest and highest addresses (0 and 31) in both banks. The serial clock runs at ten system clocks per half period. That leaves room for the synchronizer and edge-detect latency, so the bench can sample read data just before each rising edge. The same timing lets the bench drop chip-enable partway through a command or a data byte to exercise the abort paths.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_WDATA,
      ST_RDATA,
      ST_DONE
   } tws_state_t;

   localparam int unsigned BANKS = 2;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tws_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              bank,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   import tws_pkg::*;
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
      $error("tws_regfile: ADDR_W out of range 1..6");
   end

   logic [DATA_W-1:0] mem [BANKS][DEPTH];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[b][i] <= '0;
         end else if (wr_en && (bank == b[0])) begin
            mem[b][addr] <= wr_data;
         end
      end
   end

   assign rd_data = mem[bank][addr];

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R7
endmodule

// File: rtl/tws_seq.sv
module tws_seq #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              sclk_s,
   input  logic              sd_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic              bank,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sd_o,
   output logic              sd_oe
);
   import tws_pkg::*;
   localparam int unsigned CMD_W   = ADDR_W + 3;
   localparam int unsigned MAX_W   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int unsigned CNT_W   = $clog2(MAX_W + 1);
   localparam int unsigned WE_BIT  = CMD_W - 1;
   localparam int unsigned BNK_BIT = CMD_W - 2;

   tws_state_t        state;
   logic              sclk_q;
   logic              rise, fall;
   logic [CMD_W-1:0]  cmd_sr, cmd_nx;
   logic [DATA_W-1:0] dat_sr;
   logic [CNT_W-1:0]  cnt;

   assign rise   = sclk_s & ~sclk_q;
   assign fall   = ~sclk_s & sclk_q;
   assign cmd_nx = {sd_s, cmd_sr[CMD_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cmd_sr <= '0;
         dat_sr <= '0;
         cnt    <= '0;
         wr_en  <= 1'b0;
         sd_o   <= 1'b0;
         sd_oe  <= 1'b0;
      end else if (!ce_s) begin
         state <= ST_IDLE;
         cnt   <= '0;
         wr_en <= 1'b0;
         sd_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               state <= ST_CMD;
               cnt   <= '0;
            end
            ST_CMD: if (rise) begin
               cmd_sr <= cmd_nx;
               if (cnt == CNT_W'(CMD_W - 1)) begin
                  cnt   <= '0;
                  state <= cmd_nx[0] ? ST_RDATA : ST_WDATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WDATA: if (rise) begin
               dat_sr <= {sd_s, dat_sr[DATA_W-1:1]};
               if (cnt == CNT_W'(DATA_W - 1)) begin
                  wr_en <= cmd_sr[WE_BIT];
                  state <= ST_DONE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RDATA: if (fall) begin
               sd_oe <= 1'b1;
               if (cnt == '0) begin
                  sd_o   <= rd_data[0];
                  dat_sr <= rd_data >> 1;
               end else begin
                  sd_o   <= dat_sr[0];
                  dat_sr <= dat_sr >> 1;
               end
               if (cnt == CNT_W'(DATA_W - 1)) state <= ST_DONE;
               else cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign bank    = cmd_sr[BNK_BIT];
   assign addr    = cmd_sr[ADDR_W:1];
   assign wr_data = dat_sr;

   AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> !sd_oe); // R2
   AST_NO_WR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> !wr_en); // R7
   AST_WR_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> cmd_sr[WE_BIT]); // R6
   AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_oe) |-> $past(fall)); // R8
   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_oe && $past(sd_oe) && !$past(fall)) |-> $stable(sd_o)); // R8
   AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDATA) |-> !sd_oe); // R9
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   input  logic sclk_i,
   input  logic sd_i,
   output logic sd_o,
   output logic sd_oe
);
   logic [2:0]        bus_s;
   logic              wr_en, bank;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wr_data, rd_data;

   tws_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ce_i, sclk_i, sd_i}), .q(bus_s)
   );

   tws_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .ce_s(bus_s[2]), .sclk_s(bus_s[1]), .sd_s(bus_s[0]),
      .rd_data(rd_data), .wr_en(wr_en), .bank(bank), .addr(addr),
      .wr_data(wr_data), .sd_o(sd_o), .sd_oe(sd_oe)
   );

   tws_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank(bank),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
   );
endmodule

// File: tb/tb_tws_reg_slave.sv
`timescale 1ns/1ps
module tb_tws_reg_slave;
   localparam int HALF = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0, sclk = 1'b0, sd_m = 1'b0;
   logic sd_o, sd_oe;
   int   n_chk = 0, n_bad = 0;
   logic in_write = 1'b0, saw_oe_wr = 1'b0;

   always #4 clk = ~clk;

   tws_reg_slave dut (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk),
      .sd_i(sd_m), .sd_o(sd_o), .sd_oe(sd_oe)
   );

   always @(negedge clk) if (in_write && sd_oe) saw_oe_wr = 1'b1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] mk_cmd(input bit we, input bit ram,
                                         input logic [4:0] a, input bit rd);
      return {we, ram, a, rd};
   endfunction

   task automatic send_bit(input bit b);
      sclk = 1'b0; sd_m = b; waitc(HALF);
      sclk = 1'b1; waitc(HALF);
   endtask

   task automatic end_xfer();
      sclk = 1'b0; waitc(HALF);
      ce = 1'b0; waitc(HALF);
   endtask

   task automatic do_write(input bit we, input bit ram, input logic [4:0] a,
                           input logic [7:0] d, input int nbits);
      logic [7:0] c;
      c = mk_cmd(we, ram, a, 1'b0);
      in_write = 1'b1;
      ce = 1'b1; waitc(HALF);
      for (int i = 0; i < 8; i++) send_bit(c[i]);
      for (int i = 0; i < nbits; i++) send_bit(d[i]);
      end_xfer();
      in_write = 1'b0;
   endtask

   task automatic do_read(input bit ram, input logic [4:0] a, output logic [7:0] d);
      logic [7:0] c;
      c = mk_cmd(1'b1, ram, a, 1'b1);
      ce = 1'b1; waitc(HALF);
      for (int i = 0; i < 8; i++) send_bit(c[i]);
      check(sd_oe == 1'b0, "R8 oe before first data fall", sd_oe, 0);
      for (int i = 0; i < 8; i++) begin
         sclk = 1'b0; waitc(HALF);
         check(sd_oe == 1'b1, "R8 oe during read", sd_oe, 1);
         d[i] = sd_o;
         sclk = 1'b1; waitc(HALF);
      end
      end_xfer();
      waitc(4);
      check(sd_oe == 1'b0, "R2 oe after ce low", sd_oe, 0);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check(sd_oe == 1'b0, "R1 oe at reset", sd_oe, 0);
      do_read(1'b0, 5'd3, v);
      check(v == 8'h00, "R1 clock bank reset", v, 0);
      do_read(1'b1, 5'd31, v);
      check(v == 8'h00, "R1 ram bank reset", v, 0);
   endtask

   task automatic t_basic();
      logic [7:0] v;
      do_write(1'b1, 1'b0, 5'd5, 8'hA5, 8);
      do_read(1'b0, 5'd5, v);
      check(v == 8'hA5, "R3 R7 write then read", v, 8'hA5);
      do_write(1'b1, 1'b0, 5'd9, 8'h6E, 8);
      do_read(1'b0, 5'd9, v);
      check(v == 8'h6E, "R8 LSB-first read pattern", v, 8'h6E);
   endtask

   task automatic t_banks();
      logic [7:0] v;
      do_write(1'b1, 1'b1, 5'd5, 8'h3C, 8);
      do_read(1'b0, 5'd5, v);
      check(v == 8'hA5, "R5 clock bank untouched", v, 8'hA5);
      do_read(1'b1, 5'd5, v);
      check(v == 8'h3C, "R5 ram bank value", v, 8'h3C);
   endtask

   task automatic t_addr();
      logic [7:0] v;
      do_write(1'b1, 1'b0, 5'd0, 8'h01, 8);
      do_write(1'b1, 1'b0, 5'd31, 8'h80, 8);
      do_read(1'b0, 5'd0, v);
      check(v == 8'h01, "R4 address 0", v, 8'h01);
      do_read(1'b0, 5'd31, v);
      check(v == 8'h80, "R4 address 31", v, 8'h80);
      do_read(1'b0, 5'd5, v);
      check(v == 8'hA5, "R4 address 5 undisturbed", v, 8'hA5);
   endtask

   task automatic t_no_we();
      logic [7:0] v;
      do_write(1'b0, 1'b0, 5'd5, 8'hFF, 8);
      do_read(1'b0, 5'd5, v);
      check(v == 8'hA5, "R6 write blocked", v, 8'hA5);
   endtask

   task automatic t_abort();
      logic [7:0] v;
      do_write(1'b1, 1'b0, 5'd0, 8'hFE, 5);
      do_read(1'b0, 5'd0, v);
      check(v == 8'h01, "R7 aborted write", v, 8'h01);
      check(saw_oe_wr == 1'b0, "R9 oe during writes", saw_oe_wr, 0);
   endtask

   task automatic t_rearm();
      logic [7:0] v;
      logic [7:0] c;
      c = mk_cmd(1'b1, 1'b0, 5'd31, 1'b0);
      ce = 1'b1; waitc(HALF);
      for (int i = 0; i < 3; i++) send_bit(c[i]);
      end_xfer();
      do_read(1'b0, 5'd31, v);
      check(v == 8'h80, "R10 new command after partial one", v, 8'h80);
   endtask

   initial begin
      waitc(5);
      rst_n = 1'b1;
      waitc(5);
      t_reset();
      t_basic();
      t_banks();
      t_addr();
      t_no_we();
      t_abort();
      t_rearm();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule